// File: doc/BRIEF.md
# Descriptor-Driven Transfer Engine

This block moves data between memory locations under the control of per-channel records kept in shared RAM. No channel state is held inside the block. A requester raises an activation with a channel vector. The engine then does the following:

- It locates the channel's record and reads it.
- It carries out the transfer that the record asks for.
- It writes the updated fields back to the same place.

Because every channel lives in RAM, the number of channels is limited only by memory. A record may name a follower record, which the engine runs within the same activation. That hand-off can be made to depend on the counter having just reached zero, so that the follower can rewrite its predecessor's fields.

Three modes are supported:

- **Normal:** one unit per activation, ending at a zero count.
- **Repeat:** the count reloads and one side's address rewinds when the count reaches zero.
- **Block:** a whole block of units per activation, with the block side's address rewound after every block.

All record and data traffic uses a single memory master port. Its command channel is valid/ready. The engine holds a command and all of its fields unchanged until `mem_ready` accepts it. Only one access is ever in flight, and read data arrives on `mem_rvalid`, which the engine always accepts. The activation port is also valid/ready. While the engine is busy, `act_ready` stays low, so a request is not taken and waits for as long as the requester holds it.

Top module: `desc_xfer_engine`

## Requirements
- R1: `act_ready` is high only while the engine is idle, and an activation is taken when `act_valid` and `act_ready` are both high at a clock edge. `busy` is high from the next cycle until the cycle after the last record write-back is accepted. No request is taken while `busy` is high.
- R2: Channel v's record starts at byte address DESC_BASE + 16·v and consists of four 32-bit words at offsets 0, 4, 8 and 12. Chained records follow one another at 16-byte steps.
- R3: Every activation reads words 0 to 3 of the record in that order. It then writes words 0 to 2 back to the same addresses, and `busy` falls only after the write-back.
- R4: Word 0 holds the source address in bits 23:0, the mode in bits 25:24 (0 normal, 1 repeat, 2 block), the source update code in bits 27:26, the destination update code in bits 29:28, the unit size in bit 30 (0 byte, 1 halfword) and chain enable in bit 31. Each unit is read from the source address and written unchanged to the destination address.
- R5: After each unit, each address is updated by its own code: 1 adds the unit size, 2 subtracts it, and 0 or 3 leaves it unchanged.
- R6: Word 1 holds the destination address in bits 23:0, chain-only-at-zero in bit 24, the repeat/block side in bit 25 (1 source, 0 destination) and an ended flag in bit 26. In normal mode the count (word 2, bits 15:0) drops by one per activation. When it reaches zero, the ended flag is set and `xfer_end` pulses for one cycle. An activation on an ended record moves no data and leaves the record unchanged.
- R7: In repeat mode, when the count reaches zero it is reloaded from word 2 bits 31:16, the repeat-side address is set to word 3 bits 23:0, and the record never ends.
- R8: In block mode, one activation moves the number of units given in word 2 bits 31:16. The block-side address is then set to word 3, and the count drops by one per block, ending at zero as in normal mode.
- R9: With chain enable set, the record 16 bytes further on is fetched and executed in the same activation, and `busy` stays high throughout.
- R10: With chain-only-at-zero also set, chaining happens only in an activation in which the count reached zero.
- R11: Memory commands hold `mem_addr`, `mem_write`, `mem_size` and `mem_wdata` stable while `mem_valid` is high and `mem_ready` is low. Record words use size code 2, and data units use code 0 or 1. Data is right-aligned in little-endian byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Activation request |
| act_ready | output | 1 | Engine can take an activation |
| act_vec | input | VEC_W | Channel vector of the request |
| busy | output | 1 | Activation in progress |
| xfer_end | output | 1 | One-cycle pulse when a record ends |
| mem_valid | output | 1 | Memory command valid |
| mem_ready | input | 1 | Memory command accepted |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | 24 | Byte address |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Right-aligned read data |

## Verification
The close of one activation's final write-back and the arrival of the next request for the same channel can coincide. The bench provokes this by holding `act_valid` high through an entire activation while the memory inserts periodic stalls. It judges the outcome by checking that the second acceptance never overlaps `busy`, and that the second activation starts from the count and addresses the first one wrote back rather than from stale values.

// File: rtl/dxe_pkg.sv
package dxe_pkg;
  localparam int ADDR_W    = 24;
  localparam int CNT_W     = 16;
  localparam int WORD_W    = 32;
  localparam int REC_BYTES = 16;
  localparam int REC_SHIFT = $clog2(REC_BYTES);

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_BLOCK  = 2'd2,
    MODE_SPARE  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_INC   = 2'd1,
    UPD_DEC   = 2'd2,
    UPD_HOLD3 = 2'd3
  } upd_e;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    mode_e             mode;
    upd_e              src_upd;
    upd_e              dst_upd;
    logic              wide;
    logic              chain;
    logic              chain_at_zero;
    logic              side_is_src;
    logic              ended;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  reload;
    logic [ADDR_W-1:0] start;
  } desc_t;

  function automatic desc_t desc_unpack(input logic [WORD_W-1:0] w0, input logic [WORD_W-1:0] w1,
                                        input logic [WORD_W-1:0] w2, input logic [WORD_W-1:0] w3);
    desc_t d;
    d.src           = w0[ADDR_W-1:0];
    d.mode          = mode_e'(w0[25:24]);
    d.src_upd       = upd_e'(w0[27:26]);
    d.dst_upd       = upd_e'(w0[29:28]);
    d.wide          = w0[30];
    d.chain         = w0[31];
    d.dst           = w1[ADDR_W-1:0];
    d.chain_at_zero = w1[24];
    d.side_is_src   = w1[25];
    d.ended         = w1[26];
    d.count         = w2[CNT_W-1:0];
    d.reload        = w2[WORD_W-1:CNT_W];
    d.start         = w3[ADDR_W-1:0];
    return d;
  endfunction

  function automatic logic [WORD_W-1:0] desc_word(input desc_t d, input logic [1:0] idx);
    logic [WORD_W-1:0] w;
    case (idx)
      2'd0:    w = {d.chain, d.wide, d.dst_upd, d.src_upd, d.mode, d.src};
      2'd1:    w = {5'b0, d.ended, d.side_is_src, d.chain_at_zero, d.dst};
      2'd2:    w = {d.reload, d.count};
      default: w = {{(WORD_W-ADDR_W){1'b0}}, d.start};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/dxe_addr_step.sv
module dxe_addr_step
  import dxe_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  upd_e              upd,
  input  logic              wide,
  output logic [ADDR_W-1:0] next
);
  logic [ADDR_W-1:0] step;

  always_comb begin
    step = wide ? ADDR_W'(2) : ADDR_W'(1);
    case (upd)
      UPD_INC: next = addr + step;
      UPD_DEC: next = addr - step;
      default: next = addr;
    endcase
  end
endmodule

// File: rtl/dxe_count_unit.sv
module dxe_count_unit
  import dxe_pkg::*;
(
  input  mode_e            mode,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count_next,
  output logic             hit_zero,
  output logic             rewind,
  output logic             finish
);
  logic [CNT_W-1:0] dec;

  always_comb begin
    dec        = count - CNT_W'(1);
    hit_zero   = (dec == '0);
    count_next = dec;
    rewind     = 1'b0;
    finish     = 1'b0;
    case (mode)
      MODE_REPEAT: begin
        rewind = hit_zero;
        if (hit_zero) count_next = reload;
      end
      MODE_BLOCK: begin
        rewind = 1'b1;
        finish = hit_zero;
      end
      default: finish = hit_zero;
    endcase
  end
endmodule

// File: rtl/dxe_bus_port.sv
module dxe_bus_port
  import dxe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_write,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [1:0]        go_size,
  input  logic [WORD_W-1:0] go_wdata,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata
);
  typedef enum logic [1:0] {P_IDLE, P_REQ, P_RESP} phase_e;
  phase_e phase;

  assign mem_valid = (phase == P_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= P_IDLE;
      done      <= 1'b0;
      rdata     <= '0;
      mem_write <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= '0;
      mem_wdata <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        P_IDLE: if (go) begin
          mem_write <= go_write;
          mem_addr  <= go_addr;
          mem_size  <= go_size;
          mem_wdata <= go_wdata;
          phase     <= P_REQ;
        end
        P_REQ: if (mem_ready) begin
          if (mem_write) begin
            done  <= 1'b1;
            phase <= P_IDLE;
          end else begin
            phase <= P_RESP;
          end
        end
        default: if (mem_rvalid) begin
          rdata <= mem_rdata;
          done  <= 1'b1;
          phase <= P_IDLE;
        end
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)
                                && $stable(mem_size) && $stable(mem_wdata)); // R11
  AST_RESP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> phase == P_RESP); // R11
endmodule

// File: rtl/desc_xfer_engine.sv
module desc_xfer_engine
  import dxe_pkg::*;
#(
  parameter int                VEC_W     = 8,
  parameter logic [ADDR_W-1:0] DESC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_valid,
  output logic              act_ready,
  input  logic [VEC_W-1:0]  act_vec,
  output logic              busy,
  output logic              xfer_end,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int NSIDE = 2;
  localparam logic [1:0] LAST_WB = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DECIDE, S_RD, S_WR, S_UPDATE, S_WB} state_e;
  state_e state;

  desc_t             desc_q;
  logic [WORD_W-1:0] fw [4];
  logic [1:0]        widx;
  logic [ADDR_W-1:0] rec_ptr;
  logic [CNT_W-1:0]  units_left;
  logic [15:0]       data_q;
  logic              launched;
  logic              chain_go;

  logic              go, go_write;
  logic [ADDR_W-1:0] go_addr;
  logic [1:0]        go_size;
  logic [WORD_W-1:0] go_wdata;
  logic              bus_done;
  logic [WORD_W-1:0] bus_rdata;

  logic [ADDR_W-1:0] side_addr [NSIDE];
  upd_e              side_upd  [NSIDE];
  logic [ADDR_W-1:0] side_next [NSIDE];

  logic [CNT_W-1:0]  cnt_next;
  logic              cnt_zero, cnt_rewind, cnt_finish;

  assign act_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);

  assign side_addr[0] = desc_q.src;
  assign side_upd[0]  = desc_q.src_upd;
  assign side_addr[1] = desc_q.dst;
  assign side_upd[1]  = desc_q.dst_upd;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dxe_addr_step u_step (
      .addr (side_addr[s]),
      .upd  (side_upd[s]),
      .wide (desc_q.wide),
      .next (side_next[s])
    );
  end

  dxe_count_unit u_count (
    .mode       (desc_q.mode),
    .count      (desc_q.count),
    .reload     (desc_q.reload),
    .count_next (cnt_next),
    .hit_zero   (cnt_zero),
    .rewind     (cnt_rewind),
    .finish     (cnt_finish)
  );

  always_comb begin
    go       = 1'b0;
    go_write = 1'b0;
    go_addr  = '0;
    go_size  = 2'd2;
    go_wdata = '0;
    case (state)
      S_FETCH: begin
        go      = !launched;
        go_addr = rec_ptr + ADDR_W'({widx, 2'b00});
      end
      S_RD: begin
        go      = !launched;
        go_addr = desc_q.src;
        go_size = {1'b0, desc_q.wide};
      end
      S_WR: begin
        go       = !launched;
        go_write = 1'b1;
        go_addr  = desc_q.dst;
        go_size  = {1'b0, desc_q.wide};
        go_wdata = {16'b0, desc_q.wide ? data_q[15:8] : 8'b0, data_q[7:0]};
      end
      S_WB: begin
        go       = !launched;
        go_write = 1'b1;
        go_addr  = rec_ptr + ADDR_W'({widx, 2'b00});
        go_wdata = desc_word(desc_q, widx);
      end
      default: ;
    endcase
  end

  dxe_bus_port u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .go_write   (go_write),
    .go_addr    (go_addr),
    .go_size    (go_size),
    .go_wdata   (go_wdata),
    .done       (bus_done),
    .rdata      (bus_rdata),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      desc_q     <= '0;
      for (int i = 0; i < 4; i++) fw[i] <= '0;
      widx       <= '0;
      rec_ptr    <= '0;
      units_left <= '0;
      data_q     <= '0;
      launched   <= 1'b0;
      chain_go   <= 1'b0;
      xfer_end   <= 1'b0;
    end else begin
      xfer_end <= 1'b0;
      if (go) launched <= 1'b1;
      else if (bus_done) launched <= 1'b0;

      case (state)
        S_IDLE: if (act_valid) begin
          rec_ptr <= DESC_BASE + (ADDR_W'(act_vec) << REC_SHIFT);
          widx    <= '0;
          state   <= S_FETCH;
        end
        S_FETCH: if (bus_done) begin
          fw[widx] <= bus_rdata;
          if (widx == 2'd3) state <= S_DECIDE;
          else widx <= widx + 2'd1;
        end
        S_DECIDE: begin
          desc_q   <= desc_unpack(fw[0], fw[1], fw[2], fw[3]);
          chain_go <= 1'b0;
          widx     <= '0;
          if (fw[1][26]) begin
            state <= S_WB;
          end else begin
            if (mode_e'(fw[0][25:24]) == MODE_BLOCK && fw[2][WORD_W-1:CNT_W] != '0)
              units_left <= fw[2][WORD_W-1:CNT_W];
            else
              units_left <= CNT_W'(1);
            state <= S_RD;
          end
        end
        S_RD: if (bus_done) begin
          data_q <= bus_rdata[15:0];
          state  <= S_WR;
        end
        S_WR: if (bus_done) begin
          desc_q.src <= side_next[0];
          desc_q.dst <= side_next[1];
          units_left <= units_left - CNT_W'(1);
          state      <= (units_left == CNT_W'(1)) ? S_UPDATE : S_RD;
        end
        S_UPDATE: begin
          desc_q.count <= cnt_next;
          if (cnt_rewind) begin
            if (desc_q.side_is_src) desc_q.src <= desc_q.start;
            else desc_q.dst <= desc_q.start;
          end
          if (cnt_finish) begin
            desc_q.ended <= 1'b1;
            xfer_end     <= 1'b1;
          end
          chain_go <= desc_q.chain && (!desc_q.chain_at_zero || cnt_zero);
          widx     <= '0;
          state    <= S_WB;
        end
        S_WB: if (bus_done) begin
          if (widx == LAST_WB) begin
            widx <= '0;
            if (chain_go) begin
              rec_ptr <= rec_ptr + ADDR_W'(REC_BYTES);
              state   <= S_FETCH;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            widx <= widx + 2'd1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && act_ready |=> busy && !act_ready); // R1
  AST_IDLE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && $past(state) != S_IDLE) |-> $past(state) == S_WB && $past(bus_done)); // R3
  AST_END_NOT_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> desc_q.mode != MODE_REPEAT && desc_q.ended); // R6
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_WR && $past(bus_done) && $past(desc_q.src_upd) == UPD_HOLD)
      |-> desc_q.src == $past(desc_q.src)); // R5
  AST_BLOCK_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_UPDATE && desc_q.mode == MODE_BLOCK && !desc_q.side_is_src)
      |-> desc_q.dst == desc_q.start); // R8
  AST_CHAIN_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB && bus_done && widx == LAST_WB && chain_go) |=> state == S_FETCH && busy); // R9
endmodule

// File: tb/desc_xfer_engine_tb.sv
module desc_xfer_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act_valid = 1'b0;
  logic        act_ready;
  logic [7:0]  act_vec = '0;
  logic        busy, xfer_end;
  logic        mem_valid, mem_write, mem_rvalid;
  logic        mem_ready = 1'b0;
  logic [23:0] mem_addr;
  logic [1:0]  mem_size;
  logic [31:0] mem_wdata, mem_rdata;

  int checks = 0, failures = 0;
  int end_cnt = 0, acc_cnt = 0, ready_busy = 0, proto_bad = 0, stall_cnt = 0;
  bit finished = 0;
  logic [7:0] mem_b [0:1023];

  always #4 clk = ~clk;

  desc_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_ready(act_ready), .act_vec(act_vec),
    .busy(busy), .xfer_end(xfer_end), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model: one-cycle read latency, ready stalls every third cycle
  logic [31:0] rd_tmp;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_write) begin
        for (int b = 0; b < (1 << mem_size); b++) mem_b[(int'(mem_addr) + b) & 1023] <= mem_wdata[8*b +: 8];
      end else begin
        rd_tmp = '0;
        for (int b = 0; b < (1 << mem_size); b++) rd_tmp[8*b +: 8] = mem_b[(int'(mem_addr) + b) & 1023];
        mem_rdata  <= rd_tmp;
        mem_rvalid <= 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    stall_cnt++;
    mem_ready = (stall_cnt % 3) != 0;
    if (xfer_end) end_cnt++;
    if (act_ready && busy) ready_busy++;
  end

  logic        pv = 1'b0, pr = 1'b0, pw = 1'b0;
  logic [23:0] pa = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (act_valid && act_ready) acc_cnt++;
      if (pv && !pr && (!mem_valid || mem_addr != pa || mem_write != pw)) proto_bad++;
    end
    pv <= mem_valid; pr <= mem_ready; pa <= mem_addr; pw <= mem_write;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  function automatic logic [31:0] r32(input int a);
    return {mem_b[a+3], mem_b[a+2], mem_b[a+1], mem_b[a]};
  endfunction

  function automatic logic [15:0] rdv(input int a, input int sz);
    return (sz != 0) ? {mem_b[(a+1) & 1023], mem_b[a & 1023]} : {8'h00, mem_b[a & 1023]};
  endfunction

  function automatic logic [15:0] patv(input int a, input int sz);
    return (sz != 0) ? {pat(a+1), pat(a)} : {8'h00, pat(a)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int a = 0; a < 1024; a++) mem_b[a] = (a >= 256 && a < 512) ? pat(a) : 8'h00;
  endtask

  task automatic put_desc(input int vec, input int chain, input int wide, input int du, input int su,
                          input int mode, input int src, input int czero, input int side, input int dst,
                          input int cnt, input int rld, input int start);
    logic [31:0] w [4];
    int base;
    base = vec * 16;
    w[0] = {1'(chain), 1'(wide), 2'(du), 2'(su), 2'(mode), 24'(src)};
    w[1] = {5'b0, 1'b0, 1'(side), 1'(czero), 24'(dst)};
    w[2] = {16'(rld), 16'(cnt)};
    w[3] = {8'b0, 24'(start)};
    for (int i = 0; i < 4; i++)
      for (int b = 0; b < 4; b++) mem_b[base + 4*i + b] = w[i][8*b +: 8];
  endtask

  task automatic activate(input int vec);
    @(negedge clk);
    act_vec   = 8'(vec);
    act_valid = 1'b1;
    while (!act_ready) @(negedge clk);
    @(negedge clk);
    act_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s, d, st, ds, dd, e0;
    init_mem();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset act_ready", 32'(act_ready), 32'd1);
    chk("R1 reset busy", 32'(busy), 32'd0);
    chk("R11 reset mem_valid", 32'(mem_valid), 32'd0);

    // normal mode sweep: unit size x source code x destination code
    for (int sz = 0; sz < 2; sz++)
      for (int su = 0; su < 3; su++)
        for (int du = 0; du < 3; du++) begin
          init_mem();
          s = 'h180; d = 'h300; st = sz + 1;
          ds = (su == 1) ? st : (su == 2) ? -st : 0;
          dd = (du == 1) ? st : (du == 2) ? -st : 0;
          put_desc(2, 0, sz, du, su, 0, s, 0, 0, d, 2, 0, 0);
          e0 = end_cnt;
          activate(2);
          activate(2);
          for (int k = 0; k < 2; k++)
            if (du != 0 || k == 1)
              chk($sformatf("R4 data sz%0d su%0d du%0d k%0d", sz, su, du, k),
                  32'(rdv(d + k*dd, sz)), 32'(patv(s + k*ds, sz)));
          chk("R5 src after two", {8'h0, r32(32)[23:0]}, 32'((s + 2*ds) & 'hFFFFFF));
          chk("R5 dst after two", {8'h0, r32(36)[23:0]}, 32'((d + 2*dd) & 'hFFFFFF));
          chk("R2 R6 count zero", {16'h0, r32(40)[15:0]}, 32'd0);
          chk("R6 ended flag", 32'(r32(36)[26]), 32'd1);
          chk("R6 end pulse", 32'(end_cnt - e0), 32'd1);
          activate(2);
          chk("R6 ended src kept", {8'h0, r32(32)[23:0]}, 32'((s + 2*ds) & 'hFFFFFF));
          chk("R6 ended no pulse", 32'(end_cnt - e0), 32'd1);
          if (du != 0) chk("R6 ended no write", 32'(rdv(d + 2*dd, sz)), 32'd0);
        end

    // repeat mode, source side rewinds every three units
    init_mem();
    e0 = end_cnt;
    put_desc(3, 0, 0, 1, 1, 1, 'h120, 0, 1, 'h220, 3, 3, 'h120);
    for (int k = 0; k < 7; k++) activate(3);
    for (int k = 0; k < 7; k++)
      chk($sformatf("R7 repeat data k%0d", k), 32'(mem_b['h220 + k]), 32'(pat('h120 + k % 3)));
    chk("R7 repeat count", {16'h0, r32(56)[15:0]}, 32'd2);
    chk("R7 repeat src", {8'h0, r32(48)[23:0]}, 32'h121);
    chk("R7 repeat never ends", 32'(end_cnt - e0), 32'd0);
    chk("R7 repeat no ended flag", 32'(r32(52)[26]), 32'd0);

    // block mode: three halfwords per activation, destination side rewinds
    init_mem();
    e0 = end_cnt;
    put_desc(5, 0, 1, 1, 1, 2, 'h140, 0, 0, 'h260, 2, 3, 'h260);
    activate(5);
    for (int k = 0; k < 3; k++)
      chk($sformatf("R8 block1 k%0d", k), 32'(rdv('h260 + 2*k, 1)), 32'(patv('h140 + 2*k, 1)));
    chk("R8 block1 src", {8'h0, r32(80)[23:0]}, 32'h146);
    chk("R8 block1 dst rewound", {8'h0, r32(84)[23:0]}, 32'h260);
    chk("R8 block1 count", {16'h0, r32(88)[15:0]}, 32'd1);
    activate(5);
    for (int k = 0; k < 3; k++)
      chk($sformatf("R8 block2 k%0d", k), 32'(rdv('h260 + 2*k, 1)), 32'(patv('h146 + 2*k, 1)));
    chk("R8 block2 no overrun", 32'(rdv('h266, 1)), 32'd0);
    chk("R8 block2 src", {8'h0, r32(80)[23:0]}, 32'h14C);
    chk("R8 block2 ended", 32'(r32(84)[26]), 32'd1);
    chk("R8 block end pulse", 32'(end_cnt - e0), 32'd1);

    // unconditional chain 6 -> 7
    init_mem();
    put_desc(6, 1, 0, 1, 1, 0, 'h110, 0, 0, 'h210, 5, 0, 0);
    put_desc(7, 0, 0, 1, 1, 0, 'h1A0, 0, 0, 'h2A0, 5, 0, 0);
    activate(6);
    chk("R9 chain first data", 32'(mem_b['h210]), 32'(pat('h110)));
    chk("R9 chain second data", 32'(mem_b['h2A0]), 32'(pat('h1A0)));
    chk("R9 chain first count", {16'h0, r32(104)[15:0]}, 32'd4);
    chk("R9 chain second count", {16'h0, r32(120)[15:0]}, 32'd4);

    // chain only when count reaches zero, 8 -> 9
    put_desc(8, 1, 0, 1, 1, 0, 'h130, 1, 0, 'h230, 2, 0, 0);
    put_desc(9, 0, 0, 1, 1, 0, 'h1B0, 0, 0, 'h2B0, 9, 0, 0);
    activate(8);
    chk("R10 no chain before zero", {16'h0, r32(152)[15:0]}, 32'd9);
    chk("R10 no follower data", 32'(mem_b['h2B0]), 32'd0);
    activate(8);
    chk("R10 first reached zero", {16'h0, r32(136)[15:0]}, 32'd0);
    chk("R10 chain at zero count", {16'h0, r32(152)[15:0]}, 32'd8);
    chk("R10 chain at zero data", 32'(mem_b['h2B0]), 32'(pat('h1B0)));

    // held request across the end of write-back
    put_desc(10, 0, 0, 1, 1, 0, 'h150, 0, 0, 'h250, 2, 0, 0);
    e0 = acc_cnt;
    @(negedge clk);
    act_vec = 8'd10;
    act_valid = 1'b1;
    while (acc_cnt - e0 < 2) @(negedge clk);
    act_valid = 1'b0;
    while (busy) @(negedge clk);
    chk("R1 two acceptances", 32'(acc_cnt - e0), 32'd2);
    chk("R3 second saw write-back count", {16'h0, r32(168)[15:0]}, 32'd0);
    chk("R3 second saw write-back src", {8'h0, r32(160)[23:0]}, 32'h152);
    chk("R3 held data 0", 32'(mem_b['h250]), 32'(pat('h150)));
    chk("R3 held data 1", 32'(mem_b['h251]), 32'(pat('h151)));
    chk("R1 ready never while busy", 32'(ready_busy), 32'd0);
    chk("R11 command held while stalled", 32'(proto_bad), 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule